// File: doc/BRIEF.md
# Lane-Group Masked Sum Reducer

This block takes one packed vector register per cycle and adds up the elements of each 32-byte slice of it. Each slice is reduced on its own and in parallel with the others. Elements are either 16-bit or 32-bit integers, and a per-element predicate removes selected elements from the sum. Each slice's total is written into the lowest element of that slice in the result vector. Every other bit of the result vector is driven to zero.

The unit is fully pipelined and can accept a new vector on every clock. Each slice has a registered binary adder tree, so the result comes out a fixed number of cycles after the input. That count is log2 of the number of 16-bit slots in a slice, which is 4 for 32-byte slices, for both element types. A typical use is forming partial row sums, for example the exponent sums of a softmax, before a later full reduction. The vector width (`VEC_BYTES`) and the slice size (`GROUP_BYTES`) are parameters. The defaults are a 64-byte vector, which gives two slices.

Top module: `lgr_sum_reduce`

## Requirements
- R1: The vector is split into `VEC_BYTES/32` slices of 32 bytes. Slice g occupies bits `[256g +: 256]` of `in_vec` and of `out_vec`. The result of slice g depends only on the data and predicate bits of slice g's own elements.
- R2: With `in_elem_is32` = 1, element e occupies `in_vec[32e +: 32]` and is enabled by `in_mask[e]`. `out_vec[256g +: 32]` holds the sum of the enabled elements 8g to 8g+7.
- R3: With `in_elem_is32` = 0, element e occupies `in_vec[16e +: 16]` and is enabled by `in_mask[e]`. `out_vec[256g +: 16]` holds the sum of the enabled elements 16g to 16g+15.
- R4: All result bits outside a slice's lowest element are zero. With 32-bit elements these are bits 32..255 of each slice. With 16-bit elements they are bits 16..255 of each slice.
- R5: An element whose predicate bit is clear adds nothing to its slice's sum. A slice whose predicate bits are all clear yields zero in its lowest element.
- R6: Sums wrap modulo 2^32 for 32-bit elements and modulo 2^16 for 16-bit elements. There is no saturation.
- R7: `out_valid` rises exactly 4 cycles after the cycle in which `in_valid` was sampled high. It is low otherwise. Vectors may arrive on consecutive cycles, and each result belongs to the vector sampled 4 cycles earlier.
- R8: With 32-bit elements, predicate bits `in_mask[VEC_BYTES/4 ..]` (the upper half of the predicate) have no effect on the result.
- R9: While reset is held, and on the first cycle after it is released, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input vector strobe |
| in_elem_is32 | input | 1 | Element type: 1 = 32-bit integers, 0 = 16-bit integers |
| in_vec | input | VEC_BYTES*8 | Packed source vector |
| in_mask | input | VEC_BYTES/2 | Per-element predicate, one bit per element of the selected type |
| out_valid | output | 1 | Result vector strobe |
| out_vec | output | VEC_BYTES*8 | Packed result vector |

## Verification
Every result is due on the fourth rising edge after its input was sampled, whatever the element type. The bench drives inputs on falling edges. On each falling edge it compares the outputs against an expectation that was queued four falling edges earlier. Each cycle with no input queues an expectation of `out_valid` low, so bubbles and back-to-back traffic are checked against the same fixed distance. The reset check happens on the first falling edge after release, before any input could have reached the output.

// File: rtl/lgr_pkg.sv
`timescale 1ns/1ps
package lgr_pkg;
   localparam int SLOT_W = 16;
   localparam int ACC_W  = 32;

   typedef enum logic {
      ELEM_I16 = 1'b0,
      ELEM_I32 = 1'b1
   } elem_kind_e;
endpackage

// File: rtl/lgr_lane_prep.sv
`timescale 1ns/1ps
// Applies the predicate and spreads one slice onto the 32-bit tree leaves.
module lgr_lane_prep
   import lgr_pkg::*;
#(
   parameter int VEC_BYTES   = 64,
   parameter int GROUP_BYTES = 32,
   parameter int GROUP_IDX   = 0
) (
   input  elem_kind_e                      kind,
   input  logic [GROUP_BYTES*8-1:0]        grp_vec,
   input  logic [VEC_BYTES/2-1:0]          mask,
   output logic [GROUP_BYTES/2*ACC_W-1:0]  leaves
);
   localparam int GRP_W  = GROUP_BYTES * 8;
   localparam int SLOTS  = GRP_W / SLOT_W;
   localparam int WORDS  = GRP_W / ACC_W;

   logic [SLOTS*ACC_W-1:0] leaf16;
   logic [SLOTS*ACC_W-1:0] leaf32;

   always_comb begin
      leaf16 = '0;
      leaf32 = '0;
      for (int i = 0; i < SLOTS; i++) begin
         if (mask[GROUP_IDX*SLOTS + i])
            leaf16[i*ACC_W +: ACC_W] = {{(ACC_W-SLOT_W){1'b0}}, grp_vec[i*SLOT_W +: SLOT_W]};
      end
      for (int i = 0; i < WORDS; i++) begin
         if (mask[GROUP_IDX*WORDS + i])
            leaf32[(2*i)*ACC_W +: ACC_W] = grp_vec[i*ACC_W +: ACC_W];
      end
   end

   assign leaves = (kind == ELEM_I32) ? leaf32 : leaf16;
endmodule

// File: rtl/lgr_add_tree.sv
`timescale 1ns/1ps
// Registered balanced adder tree in heap order: node k adds nodes 2k+1 and 2k+2.
module lgr_add_tree
   import lgr_pkg::*;
#(
   parameter int LEAVES = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [LEAVES*ACC_W-1:0] leaves,
   output logic [ACC_W-1:0]        sum
);
   localparam int NODES = LEAVES - 1;
   localparam int ALL   = 2 * LEAVES - 1;

   if (LEAVES < 2 || (LEAVES & (LEAVES - 1)) != 0) begin : g_bad_leaves
      $error("lgr_add_tree: LEAVES must be a power of two of at least 2");
   end

   logic [ACC_W-1:0] node_q [NODES];
   logic [ACC_W-1:0] node_d [NODES];
   logic [ACC_W-1:0] all_v  [ALL];

   always_comb begin
      for (int k = 0; k < NODES; k++) all_v[k] = node_q[k];
      for (int j = 0; j < LEAVES; j++) all_v[NODES + j] = leaves[j*ACC_W +: ACC_W];
   end

   always_comb begin
      for (int k = 0; k < NODES; k++) node_d[k] = all_v[2*k + 1] + all_v[2*k + 2];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < NODES; k++) node_q[k] <= '0;
      end else begin
         for (int k = 0; k < NODES; k++) node_q[k] <= node_d[k];
      end
   end

   assign sum = node_q[0];
endmodule

// File: rtl/lgr_place.sv
`timescale 1ns/1ps
// Writes the slice total into the slice's lowest element and clears the rest.
module lgr_place
   import lgr_pkg::*;
#(
   parameter int GROUP_BYTES = 32
) (
   input  elem_kind_e               kind,
   input  logic [ACC_W-1:0]         sum,
   output logic [GROUP_BYTES*8-1:0] grp_out
);
   always_comb begin
      grp_out = '0;
      if (kind == ELEM_I32) grp_out[ACC_W-1:0]  = sum;
      else                  grp_out[SLOT_W-1:0] = sum[SLOT_W-1:0];
   end
endmodule

// File: rtl/lgr_sum_reduce.sv
`timescale 1ns/1ps
module lgr_sum_reduce
   import lgr_pkg::*;
#(
   parameter int VEC_BYTES   = 64,
   parameter int GROUP_BYTES = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic                   in_elem_is32,
   input  logic [VEC_BYTES*8-1:0] in_vec,
   input  logic [VEC_BYTES/2-1:0] in_mask,
   output logic                   out_valid,
   output logic [VEC_BYTES*8-1:0] out_vec
);
   localparam int GRP_W  = GROUP_BYTES * 8;
   localparam int GROUPS = VEC_BYTES / GROUP_BYTES;
   localparam int SLOTS  = GRP_W / SLOT_W;
   localparam int LEVELS = $clog2(SLOTS);

   if (GROUP_BYTES < 8 || (GROUP_BYTES & (GROUP_BYTES - 1)) != 0) begin : g_bad_group
      $error("lgr_sum_reduce: GROUP_BYTES must be a power of two of at least 8");
   end
   if (VEC_BYTES < GROUP_BYTES || (VEC_BYTES % GROUP_BYTES) != 0) begin : g_bad_vec
      $error("lgr_sum_reduce: VEC_BYTES must be a multiple of GROUP_BYTES");
   end

   elem_kind_e in_kind;
   assign in_kind = elem_kind_e'(in_elem_is32);

   logic [LEVELS-1:0] vld_sr;
   logic [LEVELS-1:0] kind_sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_sr  <= '0;
         kind_sr <= '0;
      end else begin
         vld_sr  <= {vld_sr[LEVELS-2:0], in_valid};
         kind_sr <= {kind_sr[LEVELS-2:0], in_elem_is32};
      end
   end

   elem_kind_e out_kind;
   assign out_kind  = elem_kind_e'(kind_sr[LEVELS-1]);
   assign out_valid = vld_sr[LEVELS-1];

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      logic [SLOTS*ACC_W-1:0] leaves;
      logic [ACC_W-1:0]       total;

      lgr_lane_prep #(
         .VEC_BYTES   (VEC_BYTES),
         .GROUP_BYTES (GROUP_BYTES),
         .GROUP_IDX   (g)
      ) u_prep (
         .kind    (in_kind),
         .grp_vec (in_vec[g*GRP_W +: GRP_W]),
         .mask    (in_mask),
         .leaves  (leaves)
      );

      lgr_add_tree #(
         .LEAVES (SLOTS)
      ) u_tree (
         .clk    (clk),
         .rst_n  (rst_n),
         .leaves (leaves),
         .sum    (total)
      );

      lgr_place #(
         .GROUP_BYTES (GROUP_BYTES)
      ) u_place (
         .kind    (out_kind),
         .sum     (total),
         .grp_out (out_vec[g*GRP_W +: GRP_W])
      );
   end
endmodule

// File: rtl/lgr_sum_reduce_chk.sv
`timescale 1ns/1ps
module lgr_sum_reduce_chk #(
   parameter int VEC_BYTES   = 64,
   parameter int GROUP_BYTES = 32
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   in_valid,
   input logic                   in_elem_is32,
   input logic [VEC_BYTES/2-1:0] in_mask,
   input logic                   out_valid,
   input logic [VEC_BYTES*8-1:0] out_vec
);
   localparam int GRP_W  = GROUP_BYTES * 8;
   localparam int GROUPS = VEC_BYTES / GROUP_BYTES;
   localparam int SLOTS  = GRP_W / 16;
   localparam int WORDS  = GRP_W / 32;
   localparam int LEVELS = $clog2(SLOTS);

   logic [GROUPS-1:0] empty_now;
   always_comb begin
      for (int g = 0; g < GROUPS; g++)
         empty_now[g] = in_elem_is32 ? (in_mask[g*WORDS +: WORDS] == '0)
                                     : (in_mask[g*SLOTS +: SLOTS] == '0);
   end

   logic [LEVELS-1:0] vld_m;
   logic [LEVELS-1:0] k32_m;
   logic [GROUPS-1:0] empty_m [LEVELS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_m <= '0;
         k32_m <= '0;
         for (int s = 0; s < LEVELS; s++) empty_m[s] <= '0;
      end else begin
         vld_m <= {vld_m[LEVELS-2:0], in_valid};
         k32_m <= {k32_m[LEVELS-2:0], in_elem_is32};
         empty_m[0] <= empty_now;
         for (int s = 1; s < LEVELS; s++) empty_m[s] <= empty_m[s-1];
      end
   end

   // R7: strobe follows the input strobe at the fixed tree depth
   a_r7_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == vld_m[LEVELS-1]);

   for (genvar g = 0; g < GROUPS; g++) begin : g_chk
      // R4: bits above the widest element are always clear
      a_r4_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> out_vec[g*GRP_W + 32 +: GRP_W - 32] == '0);
      // R4: with 16-bit elements the second slot of the slice is clear
      a_r4_i16_slot1_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && !k32_m[LEVELS-1]) |-> out_vec[g*GRP_W + 16 +: 16] == '0);
      // R5: a slice with no enabled element gives zero
      a_r5_empty_slice_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && empty_m[LEVELS-1][g]) |-> out_vec[g*GRP_W +: 32] == '0);
   end
endmodule

bind lgr_sum_reduce lgr_sum_reduce_chk #(
   .VEC_BYTES   (VEC_BYTES),
   .GROUP_BYTES (GROUP_BYTES)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .in_elem_is32 (in_elem_is32),
   .in_mask      (in_mask),
   .out_valid    (out_valid),
   .out_vec      (out_vec)
);

// File: tb/lgr_sum_reduce_tb.sv
`timescale 1ns/1ps
module lgr_sum_reduce_tb;
   localparam int VB     = 64;
   localparam int VW     = VB * 8;
   localparam int MW     = VB / 2;
   localparam int GROUPS = VB / 32;
   localparam int LAT    = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_elem_is32 = 1'b0;
   logic [VW-1:0] in_vec = '0;
   logic [MW-1:0] in_mask = '0;
   logic          out_valid;
   logic [VW-1:0] out_vec;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   lgr_sum_reduce #(.VEC_BYTES(VB), .GROUP_BYTES(32)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_elem_is32(in_elem_is32),
      .in_vec(in_vec), .in_mask(in_mask), .out_valid(out_valid), .out_vec(out_vec)
   );

   logic [VW-1:0] exp_d [LAT];
   logic          exp_v [LAT];
   string         exp_t [LAT];

   function automatic logic [VW-1:0] ref_sum(input logic [VW-1:0] d, input logic [MW-1:0] m,
                                             input logic is32);
      logic [VW-1:0] r;
      logic [31:0]   s32;
      logic [15:0]   s16;
      r = '0;
      for (int g = 0; g < GROUPS; g++) begin
         s32 = '0;
         s16 = '0;
         if (is32) begin
            for (int j = 0; j < 8; j++)
               if (m[g*8 + j]) s32 = s32 + d[(g*8 + j)*32 +: 32];
            r[g*256 +: 32] = s32;
         end else begin
            for (int j = 0; j < 16; j++)
               if (m[g*16 + j]) s16 = s16 + d[(g*16 + j)*16 +: 16];
            r[g*256 +: 16] = s16;
         end
      end
      return r;
   endfunction

   function automatic logic [VW-1:0] rnd_vec();
      logic [VW-1:0] v;
      for (int i = 0; i < VW/32; i++) v[i*32 +: 32] = $urandom;
      return v;
   endfunction

   // One cycle: check the result due now, then drive the next input.
   task automatic step(input logic v, input logic is32, input logic [VW-1:0] d,
                       input logic [MW-1:0] m, input string tag);
      @(negedge clk);
      n_tests++;
      if (out_valid !== exp_v[LAT-1]) begin
         n_fail++;
         $display("FAIL R7 (%s) out_valid actual %b expected %b", exp_t[LAT-1], out_valid,
                  exp_v[LAT-1]);
      end
      if (exp_v[LAT-1]) begin
         n_tests++;
         if (out_vec !== exp_d[LAT-1]) begin
            n_fail++;
            $display("FAIL %s out_vec actual %h expected %h", exp_t[LAT-1], out_vec,
                     exp_d[LAT-1]);
         end
      end
      for (int s = LAT-1; s > 0; s--) begin
         exp_d[s] = exp_d[s-1];
         exp_v[s] = exp_v[s-1];
         exp_t[s] = exp_t[s-1];
      end
      exp_v[0] = v;
      exp_d[0] = ref_sum(d, m, is32);
      exp_t[0] = tag;
      in_valid     = v;
      in_elem_is32 = is32;
      in_vec       = d;
      in_mask      = m;
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual running expected finished");
         finish_run();
      end
   end

   initial begin
      logic [VW-1:0] d;
      for (int s = 0; s < LAT; s++) begin
         exp_v[s] = 1'b0;
         exp_d[s] = '0;
         exp_t[s] = "R9";
      end
      repeat (3) @(negedge clk);
      n_tests++;
      if (out_valid !== 1'b0) begin
         n_fail++;
         $display("FAIL R9 out_valid in reset actual %b expected 0", out_valid);
      end
      rst_n = 1'b1;

      // R9: first cycles after release stay idle
      step(1'b0, 1'b0, '0, '0, "R9");

      // R2: sequential 32-bit values, all enabled
      for (int e = 0; e < VW/32; e++) d[e*32 +: 32] = 32'(e + 1);
      step(1'b1, 1'b1, d, '1, "R2 R4");
      // R3: 16-bit values, all enabled
      for (int e = 0; e < VW/16; e++) d[e*16 +: 16] = 16'(e * 3 + 7);
      step(1'b1, 1'b0, d, '1, "R3 R4");
      // R5: nothing enabled, both types
      step(1'b1, 1'b1, rnd_vec(), '0, "R5");
      step(1'b1, 1'b0, rnd_vec(), '0, "R5");
      // R6: wrap-around
      step(1'b1, 1'b1, '1, '1, "R6");
      step(1'b1, 1'b0, '1, '1, "R6");
      // R8: only the unused upper predicate half set in 32-bit mode
      step(1'b1, 1'b1, rnd_vec(), {{(MW/2){1'b1}}, {(MW/2){1'b0}}}, "R8");
      step(1'b1, 1'b1, rnd_vec(), {{(MW/2){1'b1}}, 16'h0081}, "R8");
      // R1: only one slice populated
      d = '0;
      d[256 +: 256] = rnd_vec();
      step(1'b1, 1'b0, d, '1, "R1");
      step(1'b1, 1'b1, d, '1, "R1");

      // R5: walking single predicate bit, every lane of both types
      for (int i = 0; i < MW; i++)
         step(1'b1, 1'b0, rnd_vec(), MW'(1) << i, "R5 R3");
      for (int i = 0; i < MW/2; i++)
         step(1'b1, 1'b1, rnd_vec(), MW'(1) << i, "R5 R2");

      // R7: bubbles and back-to-back traffic with mixed types and predicates
      for (int n = 0; n < 400; n++)
         step(($urandom % 4) != 0, 1'($urandom), rnd_vec(), MW'($urandom), "R7 R1 R2 R3");

      // drain
      for (int n = 0; n < LAT + 2; n++)
         step(1'b0, 1'b0, '0, '0, "R7");

      done = 1'b1;
      finish_run();
   end
endmodule